// File: doc/BRIEF.md
# Receive Destination Address Filter with Match Table

This block decides whether an incoming frame is for this station by looking at its 48-bit destination address, and classifies an accepted frame as multicast or broadcast where a mode grants it on that basis. It keeps a table of sixteen station addresses plus a sixteen-bit enable mask. The table is filled from a stream of 16-bit words that an external fetch engine delivers after a load command. While the load runs, every filter decision is forced to reject.

Three mode inputs are applied ahead of the table, in a fixed priority. Promiscuous mode takes every unicast frame. All-multicast mode takes every frame whose group bit is set. Broadcast mode takes the all-ones address. Only after these does an enabled table entry with an exact match accept the frame. A decision is requested with a one-cycle strobe, and the result is registered one cycle later. A read port lets software inspect the table, one 16-bit slice at a time, but only while the chip-level reset-mode bit is high.

Top module: `cam_addr_filter`

## Requirements
- R1: After reset the loader is idle (`load_busy`=0), `load_done`=0, `res_valid`=0, and the enable mask is all zero, so a frame reaches a decision only through a mode.
- R2: `load_go` samples the entry count from `load_cnt` (5 bits) and sets `load_busy`. Each `wd_valid` word is then stored in turn: three words per entry, for entries 0, 1, 2 and so on. Within an entry, word k carries address byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. `ent_left` starts at the count and drops by one each time an entry's third word is taken.
- R3: Once `ent_left` is 0, the next word becomes the enable mask, with bit i enabling entry i. That word clears `load_busy` and sets the sticky `load_done`, which `done_clr` clears. Entries the load does not reach keep their old contents.
- R4: Address byte 0 is `dst_addr[7:0]`, and its bit 0 is the group bit. With `promisc`=1, any frame whose group bit is clear is accepted with both flags 0.
- R5: Otherwise, with `all_mc`=1, any frame whose group bit is set is accepted with `res_mc`=1.
- R6: Otherwise, with `bcast_en`=1, the all-ones address is accepted with `res_bc`=1.
- R7: Otherwise, a frame is accepted with both flags 0 when its address equals an entry whose enable bit is set. Disabled entries never match.
- R8: Any other frame is rejected, with `res_accept`, `res_mc` and `res_bc` all 0.
- R9: `res_valid` is high for exactly the one cycle after each cycle in which `dst_valid` is high, and the result reflects the inputs of the strobe cycle.
- R10: A strobe that arrives while `load_busy`=1 yields a reject with both flags clear.
- R11: With `in_reset`=1, `port_data` returns bytes 2n+1:2n of the entry at `ptr`, where n is `port_sel` and the higher byte is in bits 15:8. It returns 0 when `port_sel`=3 or when `in_reset`=0.
- R12: A `wd_valid` word that arrives while no load is running changes neither the table nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_reset | input | 1 | Chip reset-mode bit; gates the read port |
| load_go | input | 1 | Start a table load |
| load_cnt | input | 5 | Number of entries to load |
| wd_valid | input | 1 | Load word strobe |
| wd_data | input | 16 | Load word |
| done_clr | input | 1 | Clear the load-done status |
| load_busy | output | 1 | Load in progress |
| load_done | output | 1 | Sticky load-complete status |
| ent_left | output | 5 | Entries still to load |
| promisc | input | 1 | Accept all unicast |
| all_mc | input | 1 | Accept all multicast |
| bcast_en | input | 1 | Accept broadcast |
| dst_valid | input | 1 | Decision request strobe |
| dst_addr | input | 48 | Destination address, byte i at bits 8i+7:8i |
| res_valid | output | 1 | Decision valid |
| res_accept | output | 1 | Frame accepted |
| res_mc | output | 1 | Accepted as multicast |
| res_bc | output | 1 | Accepted as broadcast |
| ptr | input | 4 | Entry selected for readout |
| port_sel | input | 2 | Slice selected for readout |
| port_data | output | 16 | Readout data |

## Verification
The assertions assume that `load_cnt` stays at 16 or below, so that the entry index never wraps. They also assume that `wd_valid` words arrive only after `load_go` has been dropped, and that the mode inputs are held steady across each decision strobe. The bench keeps within these limits: random loads draw counts from 0 to 16, words are driven one per cycle after the start pulse, and modes and addresses change only on the falling edge of the cycle before a strobe. Addresses are drawn from the loaded entries, the broadcast address, near misses of entries, and random values with either group bit, so that every priority level gets hit.

// File: rtl/cam_addr_filter.sv
module cam_addr_filter #(
  parameter int NUM_ENT = 16,
  parameter int CNT_W   = 5,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_reset,
  input  logic              load_go,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              wd_valid,
  input  logic [WORD_W-1:0] wd_data,
  input  logic              done_clr,
  output logic              load_busy,
  output logic              load_done,
  output logic [CNT_W-1:0]  ent_left,
  input  logic              promisc,
  input  logic              all_mc,
  input  logic              bcast_en,
  input  logic              dst_valid,
  input  logic [ADDR_W-1:0] dst_addr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_mc,
  output logic              res_bc,
  input  logic [$clog2(NUM_ENT)-1:0] ptr,
  input  logic [1:0]        port_sel,
  output logic [WORD_W-1:0] port_data
);
  localparam int IDX_W  = $clog2(NUM_ENT);
  localparam int WPE    = ADDR_W / WORD_W;
  localparam int WSEL_W = 2;

  logic [NUM_ENT-1:0][ADDR_W-1:0] cam_q;
  logic [NUM_ENT-1:0]             en_q;
  logic [IDX_W-1:0]               idx_q;
  logic [WSEL_W-1:0]              wsel_q;
  logic [NUM_ENT-1:0]             hit;
  logic                           acc_d, mc_d, bc_d;
  logic                           grp_bit, all_ones;

  wire take_word = load_busy && wd_valid && !load_go;
  wire last_word = take_word && (ent_left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cam_q     <= '0;
      en_q      <= '0;
      idx_q     <= '0;
      wsel_q    <= '0;
      ent_left  <= '0;
      load_busy <= 1'b0;
    end else if (load_go) begin
      load_busy <= 1'b1;
      ent_left  <= load_cnt;
      idx_q     <= '0;
      wsel_q    <= '0;
    end else if (take_word) begin
      if (ent_left == '0) begin
        en_q      <= wd_data[NUM_ENT-1:0];
        load_busy <= 1'b0;
      end else begin
        cam_q[idx_q][wsel_q*WORD_W +: WORD_W] <= wd_data;
        if (wsel_q == WSEL_W'(WPE-1)) begin
          wsel_q   <= '0;
          idx_q    <= idx_q + 1'b1;
          ent_left <= ent_left - 1'b1;
        end else begin
          wsel_q <= wsel_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         load_done <= 1'b0;
    else if (last_word) load_done <= 1'b1;
    else if (done_clr)  load_done <= 1'b0;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENT; gi++) begin : g_match
      assign hit[gi] = en_q[gi] && (cam_q[gi] == dst_addr);
    end
  endgenerate

  assign grp_bit  = dst_addr[0];
  assign all_ones = &dst_addr;

  always_comb begin
    acc_d = 1'b0;
    mc_d  = 1'b0;
    bc_d  = 1'b0;
    if (!load_busy) begin
      if (promisc && !grp_bit) begin
        acc_d = 1'b1;
      end else if (all_mc && grp_bit) begin
        acc_d = 1'b1;
        mc_d  = 1'b1;
      end else if (bcast_en && all_ones) begin
        acc_d = 1'b1;
        bc_d  = 1'b1;
      end else if (|hit) begin
        acc_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_mc     <= 1'b0;
      res_bc     <= 1'b0;
    end else begin
      res_valid  <= dst_valid;
      res_accept <= dst_valid && acc_d;
      res_mc     <= dst_valid && mc_d;
      res_bc     <= dst_valid && bc_d;
    end
  end

  always_comb begin
    port_data = '0;
    if (in_reset) begin
      for (int k = 0; k < WPE; k++)
        if (port_sel == WSEL_W'(k)) port_data = cam_q[ptr][k*WORD_W +: WORD_W];
    end
  end

  // R9
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> res_valid);
  // R9
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !res_valid);
  // R10
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && load_busy && !load_go) |=> !res_accept && !res_mc && !res_bc);
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_mc && res_bc));
  // R8
  flag_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mc || res_bc) |-> res_accept);
  // R3
  load_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> !load_busy && load_done);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_word && ent_left != '0 && wsel_q == WSEL_W'(WPE-1)) |=> ent_left == $past(ent_left) - 1'b1);
  // R11
  port_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_reset |-> port_data == '0);
  // R12
  idle_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_busy && !load_go) |=> $stable(en_q) && $stable(cam_q));
endmodule

// File: tb/cam_addr_filter_tb.sv
module cam_addr_filter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_reset = 1'b0, load_go = 1'b0, wd_valid = 1'b0, done_clr = 1'b0;
  logic [4:0] load_cnt = '0;
  logic [15:0] wd_data = '0;
  logic load_busy, load_done, res_valid, res_accept, res_mc, res_bc;
  logic [4:0] ent_left;
  logic promisc = 1'b0, all_mc = 1'b0, bcast_en = 1'b0, dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic [3:0] ptr = '0;
  logic [1:0] port_sel = '0;
  logic [15:0] port_data;

  int tests = 0, fails = 0;
  bit done_flag = 0;
  logic [47:0] m_cam [16];
  logic [15:0] m_en = '0;

  always #10 clk = ~clk;

  cam_addr_filter u_dut (.clk, .rst_n, .in_reset, .load_go, .load_cnt, .wd_valid,
    .wd_data, .done_clr, .load_busy, .load_done, .ent_left, .promisc, .all_mc,
    .bcast_en, .dst_valid, .dst_addr, .res_valid, .res_accept, .res_mc, .res_bc,
    .ptr, .port_sel, .port_data);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_dec(logic [47:0] a, logic p, logic m, logic b, logic busy);
    if (busy) return 3'b000;
    if (p && !a[0]) return 3'b100;
    if (m && a[0]) return 3'b110;
    if (b && (&a)) return 3'b101;
    for (int i = 0; i < 16; i++) if (m_en[i] && m_cam[i] == a) return 3'b100;
    return 3'b000;
  endfunction

  task automatic send_word(logic [15:0] w);
    @(negedge clk); wd_valid = 1'b1; wd_data = w;
    @(negedge clk); wd_valid = 1'b0;
  endtask

  task automatic start_load(int cnt);
    @(negedge clk); load_go = 1'b1; load_cnt = 5'(cnt);
    @(negedge clk); load_go = 1'b0;
  endtask

  task automatic do_load(int cnt, logic [15:0] mask, bit step_chk);
    start_load(cnt);
    chk("R2 busy", load_busy, 1);
    for (int e = 0; e < cnt; e++) begin
      logic [47:0] a = {$urandom, $urandom};
      if ($urandom % 4 == 0) a[0] = 1'b1;
      m_cam[e] = a;
      for (int k = 0; k < 3; k++) send_word(a[k*16 +: 16]);
      if (step_chk) chk("R2 ent_left", ent_left, 5'(cnt - e - 1));
    end
    send_word(mask);
    m_en = mask;
    chk("R3 busy clear", load_busy, 0);
    chk("R3 done set", load_done, 1);
  endtask

  task automatic decide(logic [47:0] a, logic p, logic m, logic b, string req);
    logic [2:0] e;
    @(negedge clk);
    dst_addr = a; promisc = p; all_mc = m; bcast_en = b; dst_valid = 1'b1;
    e = exp_dec(a, p, m, b, load_busy);
    @(negedge clk); dst_valid = 1'b0;
    chk({req, " R9 valid"}, res_valid, 1);
    chk(req, {res_accept, res_mc, res_bc}, e);
    @(negedge clk);
    chk("R9 single", res_valid, 0);
  endtask

  task automatic read_entry(int i, string req);
    @(negedge clk); in_reset = 1'b1; ptr = 4'(i);
    for (int k = 0; k < 4; k++) begin
      port_sel = 2'(k); #1;
      chk(req, port_data, k < 3 ? m_cam[i][k*16 +: 16] : 16'h0);
    end
    in_reset = 1'b0; #1;
    chk("R11 gated", port_data, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 16; i++) m_cam[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", load_busy, 0);
    chk("R1 done", load_done, 0);
    chk("R1 valid", res_valid, 0);
    decide(48'h0, 0, 0, 0, "R1 empty mask rejects");

    // R2 R3 directed load with byte order check
    start_load(1);
    m_cam[0] = 48'h665544332211;
    send_word(16'h2211); send_word(16'h4433); send_word(16'h6655);
    chk("R2 ent_left", ent_left, 0);
    send_word(16'h0001); m_en = 16'h0001;
    chk("R3 done", load_done, 1);
    read_entry(0, "R2 R11 byte order");
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk("R3 done_clr", load_done, 0);
    decide(48'h665544332211, 0, 0, 0, "R7 match");
    decide(48'h665544332210, 0, 0, 0, "R8 miss");

    // R12 idle word ignored
    send_word(16'hffff);
    read_entry(0, "R12 table kept");
    decide(48'h665544332211, 0, 0, 0, "R12 mask kept");

    // R10 busy forces reject
    start_load(0);
    decide(48'h665544332210, 1, 0, 0, "R10 busy reject");
    send_word(16'h0000); m_en = 16'h0000;
    decide(48'h665544332211, 0, 0, 0, "R7 disabled entry");

    // R4 R5 R6 priority corners
    decide(48'hffffffffffff, 1, 1, 1, "R5 bcast as mc");
    decide(48'hffffffffffff, 1, 0, 1, "R6 bcast");
    decide(48'h000000000010, 1, 1, 1, "R4 promisc unicast");
    decide(48'h000000000011, 1, 0, 0, "R8 promisc skips mc");

    // R3 partial load keeps old entries
    do_load(16, 16'hffff, 1);
    do_load(2, 16'h0008, 0);
    read_entry(3, "R3 old entry kept");
    decide(m_cam[3], 0, 0, 0, "R3 R7 old entry enabled");

    // random
    for (int it = 0; it < 60; it++) begin
      if (it % 10 == 0) do_load($urandom % 17, 16'($urandom), 0);
      for (int j = 0; j < 8; j++) begin
        logic [47:0] a;
        case ($urandom % 4)
          0: a = m_cam[$urandom % 16];
          1: a = 48'hffffffffffff;
          2: begin a = m_cam[$urandom % 16]; a[20] = ~a[20]; end
          default: a = {$urandom, $urandom};
        endcase
        decide(a, 1'($urandom), 1'($urandom), 1'($urandom), "R4-8 random");
      end
      read_entry($urandom % 16, "R11 random read");
    end

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule